// File: doc/BRIEF.md
# Sequential Restoring Unsigned Divider

This block divides one 32-bit unsigned integer by another over a fixed number of clock cycles. A single-cycle `start` pulse captures the dividend and the divisor. One quotient bit is then produced per cycle, most significant bit first, by the restoring method. The partial remainder and the growing quotient share one 64-bit working register. The divisor register and the trial subtractor are only one word wide. The divisor stays still, and on each step the working register moves up by one place before the subtraction is tried.

On completion the remainder appears on `hi` and the quotient on `lo`, and `done` pulses for one cycle. Both results are registered and keep their values until a later operation finishes. A zero divisor is not an error. The quotient comes out as all ones and the remainder equals the dividend, which is what the unmodified restoring steps produce for a zero divisor.

A surrounding pipeline raises `start` whenever `busy` is low. It may raise `start` in the very cycle that `done` is high, so divisions can run back to back with no idle cycle between them.

Top module: `seq_divider`

## Requirements
- R1: While reset is asserted and until the first accepted start, `busy`, `done`, `hi` and `lo` are all zero.
- R2: A `start` seen high at a clock edge while `busy` is low is accepted. `busy` is high from the next cycle and stays high for exactly 33 cycles.
- R3: For a nonzero divisor, `lo` holds the dividend divided by the divisor, rounded down, once the operation completes.
- R4: For a nonzero divisor, `hi` holds the dividend modulo the divisor once the operation completes.
- R5: `done` is high for exactly one cycle per accepted start, in the first cycle in which `busy` is low again.
- R6: `hi` and `lo` change only in the cycle where `done` rises. Between completions they hold their values whatever happens on `dividend` and `divisor`.
- R7: A `start` pulse that arrives while `busy` is high is ignored. It does not shorten or lengthen the running operation or change its result.
- R8: A zero divisor gives `lo` equal to 32'hFFFF_FFFF and `hi` equal to the dividend, with normal timing.
- R9: A `start` raised in the cycle where `done` is high is accepted. `busy` is high in the next cycle, and the new results appear 33 cycles after that.
- R10: A divisor larger than the dividend gives `lo` equal to zero and `hi` equal to the dividend.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset. Its release is synchronised inside the block. |
| start | input | 1 | Pulse that begins a division when the block is idle |
| dividend | input | 32 | Unsigned dividend, sampled when a start is accepted |
| divisor | input | 32 | Unsigned divisor, sampled when a start is accepted |
| busy | output | 1 | High while a division is in progress |
| done | output | 1 | One-cycle pulse when the results are updated |
| hi | output | 32 | Remainder of the last completed division |
| lo | output | 32 | Quotient of the last completed division |

## Verification
Completion of one division and acceptance of the next can fall in the same cycle. This happens when `start` is high while `done` is high.

The bench provokes this case by waiting for `done` at the falling edge and raising `start` with new operands in that same cycle. It then judges three things. The first results must still be on `hi`/`lo` while `busy` is already high. `done` must not repeat. The second results must arrive exactly 33 cycles later. A second overlap is also exercised: a `start` that lands mid-run must leave both the timing and the result of the running division unchanged.

// File: rtl/div_pkg.sv
package div_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } div_state_e;

endpackage

// File: rtl/div_step.sv
// One restoring step: bring the next dividend bit into the partial
// remainder, try the subtraction, keep or restore, emit a quotient bit.
module div_step #(
  parameter int W = 32
) (
  input  logic [W-1:0] part_rem,
  input  logic         next_bit,
  input  logic [W-1:0] divisor,
  output logic [W-1:0] new_rem,
  output logic         q_bit
);

  logic [W:0] shifted;
  logic [W:0] trial;
  logic       negative;

  always_comb begin
    shifted  = {part_rem, next_bit};
    trial    = shifted - {1'b0, divisor};
    negative = trial[W];
    q_bit    = ~negative;
    new_rem  = negative ? shifted[W-1:0] : trial[W-1:0];
  end

endmodule

// File: rtl/div_ctrl.sv
module div_ctrl
  import div_pkg::*;
#(
  parameter int ITERS = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic load_en,
  output logic iter_en,
  output logic fin_en,
  output logic busy,
  output logic done
);

  localparam int CW = (ITERS > 1) ? $clog2(ITERS) : 1;
  localparam logic [CW-1:0] LAST = CW'(ITERS - 1);

  div_state_e    state_q, state_d;
  logic [CW-1:0] count_q, count_d;
  logic          count_en;
  logic          done_q;

  assign load_en  = (state_q == ST_IDLE) && start;
  assign iter_en  = (state_q == ST_RUN);
  assign fin_en   = (state_q == ST_FIN);
  assign busy     = (state_q != ST_IDLE);
  assign done     = done_q;
  assign count_en = load_en || iter_en;

  always_comb begin
    state_d = state_q;
    count_d = count_q;
    case (state_q)
      ST_IDLE: begin
        if (start) begin
          state_d = ST_RUN;
          count_d = '0;
        end
      end
      ST_RUN: begin
        count_d = count_q + 1'b1;
        if (count_q == LAST) state_d = ST_FIN;
      end
      ST_FIN:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= fin_en;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        count_q <= '0;
    else if (count_en) count_q <= count_d;
  end

  assert_busy_on_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

  assert_start_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (iter_en && start) |=> (busy && (count_q == $past(count_q) + 1'b1 || fin_en)));

  assert_done_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_after_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy || load_en == 1'b0) && $past(busy));

  assert_back_to_back_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && start) |=> busy);

endmodule

// File: rtl/div_regs.sv
module div_regs #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_en,
  input  logic         iter_en,
  input  logic         fin_en,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic [W-1:0] hi,
  output logic [W-1:0] lo
);

  localparam int RW = 2 * W;

  logic [RW-1:0] work_q, work_d;
  logic [W-1:0]  dvsr_q;
  logic [W-1:0]  hi_q, lo_q;
  logic [W-1:0]  step_rem;
  logic          step_bit;
  logic          work_en;

  div_step #(.W(W)) u_step (
    .part_rem (work_q[RW-1:W]),
    .next_bit (work_q[W-1]),
    .divisor  (dvsr_q),
    .new_rem  (step_rem),
    .q_bit    (step_bit)
  );

  assign work_en = load_en || iter_en;

  always_comb begin
    if (load_en) work_d = {{W{1'b0}}, dividend};
    else         work_d = {step_rem, work_q[W-2:0], step_bit};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       work_q <= '0;
    else if (work_en) work_q <= work_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       dvsr_q <= '0;
    else if (load_en) dvsr_q <= divisor;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q <= '0;
      lo_q <= '0;
    end else if (fin_en) begin
      hi_q <= work_q[RW-1:W];
      lo_q <= work_q[W-1:0];
    end
  end

  assign hi = hi_q;
  assign lo = lo_q;

  assert_rem_below_dvsr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (iter_en && dvsr_q != '0) |-> (work_q[RW-1:W] < dvsr_q));

  assert_result_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !fin_en |=> ($stable(hi_q) && $stable(lo_q)));

endmodule

// File: rtl/seq_divider.sv
module seq_divider #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] hi,
  output logic [W-1:0] lo
);

  localparam int ITERS = W;

  logic rst_meta_q, rst_sync_q;
  logic load_en, iter_en, fin_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  div_ctrl #(.ITERS(ITERS)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_sync_q),
    .start   (start),
    .load_en (load_en),
    .iter_en (iter_en),
    .fin_en  (fin_en),
    .busy    (busy),
    .done    (done)
  );

  div_regs #(.W(W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_sync_q),
    .load_en  (load_en),
    .iter_en  (iter_en),
    .fin_en   (fin_en),
    .dividend (dividend),
    .divisor  (divisor),
    .hi       (hi),
    .lo       (lo)
  );

  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_sync_q |-> (!busy && !done && hi == '0 && lo == '0));

endmodule

// File: tb/tb_seq_divider.sv
module tb_seq_divider;

  localparam int LAT = 33;

  logic        clk;
  logic        rst_n;
  logic        start;
  logic [31:0] dividend;
  logic [31:0] divisor;
  logic        busy;
  logic        done;
  logic [31:0] hi;
  logic [31:0] lo;

  int total = 0;
  int bad   = 0;

  seq_divider dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .dividend (dividend),
    .divisor  (divisor),
    .busy     (busy),
    .done     (done),
    .hi       (hi),
    .lo       (lo)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_q(input logic [31:0] a, input logic [31:0] b);
    return (b == 0) ? 32'hFFFF_FFFF : a / b;
  endfunction

  function automatic logic [31:0] exp_r(input logic [31:0] a, input logic [31:0] b);
    return (b == 0) ? a : a % b;
  endfunction

  // raises start at a falling edge, drops it at the next falling edge
  task automatic launch(input logic [31:0] a, input logic [31:0] b);
    start    = 1'b1;
    dividend = a;
    divisor  = b;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(output int n);
    n = 0;
    while (!done && n < 200) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic run_one(input logic [31:0] a, input logic [31:0] b, input string req);
    int n;
    launch(a, b);
    check(busy === 1'b1, "R2 busy after start", {31'd0, busy}, 32'd1);
    wait_done(n);
    check(n == LAT, "R2 latency", n, LAT);
    check(busy === 1'b0, "R5 busy low at done", {31'd0, busy}, 32'd0);
    check(lo === exp_q(a, b), {req, " quotient"}, lo, exp_q(a, b));
    check(hi === exp_r(a, b), {req, " remainder"}, hi, exp_r(a, b));
    @(negedge clk);
    check(done === 1'b0, "R5 done one cycle", {31'd0, done}, 32'd0);
  endtask

  task automatic t_reset;
    rst_n = 1'b0; start = 1'b0; dividend = '0; divisor = '0;
    repeat (3) @(negedge clk);
    check(busy === 1'b0 && done === 1'b0, "R1 flags in reset", {30'd0, busy, done}, 32'd0);
    check(hi === 32'd0 && lo === 32'd0, "R1 results in reset", hi | lo, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(busy === 1'b0 && hi === 32'd0, "R1 idle after release", hi, 32'd0);
  endtask

  task automatic t_patterns;
    run_one(32'd108, 32'd12, "R3 R4 108/12");
    run_one(32'd1000, 32'd7, "R3 R4 1000/7");
    run_one(32'hFFFF_FFFF, 32'd1, "R3 R4 max/1");
    run_one(32'hFFFF_FFFF, 32'hFFFF_FFFF, "R3 R4 max/max");
    run_one(32'h8000_0000, 32'd3, "R3 R4 msb/3");
    run_one(32'hDEAD_BEEF, 32'h8000_0001, "R3 R4 big divisor");
    run_one(32'h1234_5678, 32'h0000_0100, "R3 R4 power of two");
  endtask

  task automatic t_small_over_big;
    run_one(32'd5, 32'd9, "R10 small/big");
    run_one(32'd0, 32'd77, "R10 zero dividend");
  endtask

  task automatic t_div_zero;
    run_one(32'hCAFE_F00D, 32'd0, "R8 divide by zero");
    run_one(32'd0, 32'd0, "R8 zero by zero");
  endtask

  task automatic t_ignore_start;
    int n;
    launch(32'd999_999, 32'd1000);
    repeat (5) @(negedge clk);
    start = 1'b1; dividend = 32'd50; divisor = 32'd5;
    @(negedge clk);
    start = 1'b0;
    wait_done(n);
    check(n + 6 == LAT, "R7 latency unchanged", n + 6, LAT);
    check(lo === 32'd999, "R7 quotient of first op", lo, 32'd999);
    check(hi === 32'd999, "R7 remainder of first op", hi, 32'd999);
    @(negedge clk);
    check(busy === 1'b0, "R7 no second op started", {31'd0, busy}, 32'd0);
  endtask

  task automatic t_hold;
    run_one(32'd77, 32'd10, "R3 hold setup");
    for (int i = 0; i < 10; i++) begin
      dividend = 32'hA5A5_0000 + i;
      divisor  = 32'd3 + i;
      @(negedge clk);
    end
    check(lo === 32'd7, "R6 quotient held", lo, 32'd7);
    check(hi === 32'd7, "R6 remainder held", hi, 32'd7);
    check(done === 1'b0 && busy === 1'b0, "R6 stays idle", {30'd0, busy, done}, 32'd0);
  endtask

  task automatic t_back_to_back;
    int n;
    launch(32'd400, 32'd30);
    wait_done(n);
    check(lo === 32'd13 && hi === 32'd10, "R9 first result", lo, 32'd13);
    launch(32'd65_536, 32'd255);
    check(busy === 1'b1, "R9 second accepted", {31'd0, busy}, 32'd1);
    check(done === 1'b0, "R9 no repeat done", {31'd0, done}, 32'd0);
    check(lo === 32'd13 && hi === 32'd10, "R6 first result kept", hi, 32'd10);
    wait_done(n);
    check(n == LAT, "R9 second latency", n, LAT);
    check(lo === 32'd257, "R9 second quotient", lo, 32'd257);
    check(hi === 32'd1, "R9 second remainder", hi, 32'd1);
    @(negedge clk);
  endtask

  initial begin
    repeat (100_000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_patterns();
    t_small_over_big();
    t_div_zero();
    t_ignore_start();
    t_hold();
    t_back_to_back();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule